// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers interrupt requests from a set of maskable device lines and one non-maskable source. It holds each request in a sticky pending bit and chooses a single winner by fixed priority. It then steps a small CPU-side sequence through four phases: saving state, presenting the vector, waiting for service, and restoring state. Requests are considered only at an instruction boundary, which the CPU marks with a one-cycle `exec_done` pulse at the end of its execute phase, before the next fetch.

When a request is accepted, the block pulses `save_stb` so that execution context can be backed up. It then offers the vector index and the service-routine start address on a valid/ready channel. The address comes from a parameterised vector table. The acknowledge that clears the chosen pending bit leaves on the handshake. The CPU signals that the routine has finished with `eoi`. The block answers with `restore_stb`, puts the interrupt-enable flag back to its earlier value, and returns to idle. While `take_valid` is high and `take_ready` is low, the offer is held unchanged for as long as needed. Apart from that single channel, all pins are plain levels or one-cycle strobes.

Top module: `irq_ctrl`

## Requirements
- R1: An idle controller starts an acceptance only on a clock edge where `exec_done` is high and an eligible request is pending. Without `exec_done`, pending requests never make `busy` rise.
- R2: A maskable line is eligible only while `ie_flag` is 1. With `ie_flag` at 0, pending maskable requests cause no acceptance.
- R3: A pending non-maskable request is eligible whatever the value of `ie_flag`.
- R4: Priority is fixed: the non-maskable source comes first, then maskable line 0, then line 1, and so on. The vector index is 0 for the non-maskable source and k+1 for maskable line k.
- R5: A request that is high for a single cycle stays pending until that source is acknowledged. The acknowledge outputs `nmi_ack`/`irq_ack` are one-hot, and they pulse only in the cycle of the vector handshake.
- R6: On the cycle after acceptance, `save_stb` is high for exactly one cycle and `ie_flag` reads 0.
- R7: The cycle after `save_stb`, `take_valid` rises with `take_idx` and `take_addr = VEC_BASE + take_idx*VEC_STRIDE`. Both stay stable until `take_ready` is seen.
- R8: After the handshake, `busy` stays high and no new acceptance happens (no nesting) until `eoi`. The cycle after `eoi`, `restore_stb` pulses once. The cycle after that, `busy` is 0 and `ie_flag` holds the value it had before acceptance.
- R9: After reset, `busy`, `save_stb`, `take_valid`, `restore_stb`, all acknowledges and `ie_flag` are 0, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_LINES | Maskable request lines, bit k is line k |
| nmi_req | input | 1 | Non-maskable request |
| exec_done | input | 1 | End-of-execute pulse marking the instruction boundary |
| ie_wr | input | 1 | Write strobe for the interrupt-enable flag |
| ie_wdata | input | 1 | Value written to the enable flag |
| eoi | input | 1 | End of service routine |
| take_ready | input | 1 | CPU accepts the offered vector |
| ie_flag | output | 1 | Current interrupt-enable flag |
| busy | output | 1 | An interrupt sequence is in progress |
| save_stb | output | 1 | One-cycle strobe to back up context |
| take_valid | output | 1 | Vector offer valid |
| take_idx | output | IDX_W | Vector index of the winner |
| take_addr | output | ADDR_W | Service-routine start address |
| nmi_ack | output | 1 | Acknowledge to the non-maskable source |
| irq_ack | output | N_LINES | Acknowledge to each maskable line |
| restore_stb | output | 1 | One-cycle strobe to restore context |

## Verification
The bench builds the block with four maskable lines, a table base of 0x100 and a stride of 0x10. With these values every index from 0 to 4 has its own address, so a wrong priority or a wrong table entry shows up in `take_addr`. Four lines are enough to test a winner at the lowest, a middle and the highest maskable index, each with and without the non-maskable source and the enable flag. The short table lets every entry be compared with the expected one.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SAVE = 3'd1,
    ST_VEC  = 3'd2,
    ST_SERV = 3'd3,
    ST_REST = 3'd4
  } seq_state_t;
endpackage

// File: rtl/irq_pend_bit.sv
module irq_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic pend
);
  // sticky latch: set while requested, cleared only by its acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (clr) pend <= 1'b0;
    else if (req) pend <= 1'b1;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 5,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] win
);
  // bit 0 is highest priority; lowest set bit wins
  always_comb begin
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) win = IDX_W'(i);
    end
    any = |cand;
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int                NV         = 5,
  parameter int                IDX_W      = 3,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0100,
  parameter logic [ADDR_W-1:0] VEC_STRIDE = 16'h0010
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] entry [NV];

  for (genvar g = 0; g < NV; g++) begin : g_entry
    assign entry[g] = VEC_BASE + ADDR_W'(g) * VEC_STRIDE;
  end

  always_comb begin
    addr = VEC_BASE;
    for (int i = 0; i < NV; i++) begin
      if (idx == IDX_W'(i)) addr = entry[i];
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_ctrl_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_done,
  input  logic             elig_any,
  input  logic [IDX_W-1:0] elig_win,
  input  logic             ie_wr,
  input  logic             ie_wdata,
  input  logic             take_ready,
  input  logic             eoi,
  output logic             ie_q,
  output logic [IDX_W-1:0] sel_q,
  output logic             in_save,
  output logic             in_vec,
  output logic             in_rest,
  output logic             in_busy,
  output logic             handshake
);
  seq_state_t state;
  logic       ie_keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ie_q    <= 1'b0;
      ie_keep <= 1'b0;
      sel_q   <= '0;
    end else begin
      if (ie_wr) ie_q <= ie_wdata;
      unique case (state)
        ST_IDLE: begin
          if (exec_done && elig_any) begin
            sel_q   <= elig_win;
            ie_keep <= ie_wr ? ie_wdata : ie_q;
            ie_q    <= 1'b0;
            state   <= ST_SAVE;
          end
        end
        ST_SAVE: state <= ST_VEC;
        ST_VEC:  if (take_ready) state <= ST_SERV;
        ST_SERV: if (eoi) state <= ST_REST;
        ST_REST: begin
          ie_q  <= ie_keep;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_save   = (state == ST_SAVE);
  assign in_vec    = (state == ST_VEC);
  assign in_rest   = (state == ST_REST);
  assign in_busy   = (state != ST_IDLE);
  assign handshake = in_vec && take_ready;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int                N_LINES    = 4,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 16'h0100,
  parameter logic [ADDR_W-1:0] VEC_STRIDE = 16'h0010,
  localparam int               N_SRC      = N_LINES + 1,
  localparam int               IDX_W      = $clog2(N_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic               nmi_req,
  input  logic               exec_done,
  input  logic               ie_wr,
  input  logic               ie_wdata,
  input  logic               eoi,
  input  logic               take_ready,
  output logic               ie_flag,
  output logic               busy,
  output logic               save_stb,
  output logic               take_valid,
  output logic [IDX_W-1:0]   take_idx,
  output logic [ADDR_W-1:0]  take_addr,
  output logic               nmi_ack,
  output logic [N_LINES-1:0] irq_ack,
  output logic               restore_stb
);
  // source numbering equals vector index: 0 = non-maskable, k+1 = line k
  logic [N_SRC-1:0] src_req;
  logic [N_SRC-1:0] src_ack;
  logic [N_SRC-1:0] src_pend;
  logic [N_SRC-1:0] src_elig;
  logic             elig_any;
  logic [IDX_W-1:0] elig_win;
  logic [IDX_W-1:0] sel_q;
  logic             handshake;

  assign src_req = {irq_req, nmi_req};

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    irq_pend_bit u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (src_req[s]),
      .clr  (src_ack[s]),
      .pend (src_pend[s])
    );
    if (s == 0) begin : g_nm
      assign src_elig[s] = src_pend[s];
    end else begin : g_mk
      assign src_elig[s] = src_pend[s] & ie_flag;
    end
    assign src_ack[s] = handshake && (sel_q == IDX_W'(s));
  end

  irq_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .cand(src_elig),
    .any (elig_any),
    .win (elig_win)
  );

  irq_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_done (exec_done),
    .elig_any  (elig_any),
    .elig_win  (elig_win),
    .ie_wr     (ie_wr),
    .ie_wdata  (ie_wdata),
    .take_ready(take_ready),
    .eoi       (eoi),
    .ie_q      (ie_flag),
    .sel_q     (sel_q),
    .in_save   (save_stb),
    .in_vec    (take_valid),
    .in_rest   (restore_stb),
    .in_busy   (busy),
    .handshake (handshake)
  );

  irq_vec_table #(
    .NV(N_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_tab (
    .idx (sel_q),
    .addr(take_addr)
  );

  assign take_idx = sel_q;
  assign nmi_ack  = src_ack[0];
  assign irq_ack  = src_ack[N_SRC-1:1];
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_LINES = 4,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exec_done,
  input logic               eoi,
  input logic               take_ready,
  input logic               ie_flag,
  input logic               busy,
  input logic               save_stb,
  input logic               take_valid,
  input logic [IDX_W-1:0]   take_idx,
  input logic [ADDR_W-1:0]  take_addr,
  input logic               nmi_ack,
  input logic [N_LINES-1:0] irq_ack,
  input logic               restore_stb
);
  assert_start_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(exec_done));

  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, nmi_ack}));

  assert_ack_on_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack || (|irq_ack)) |-> (take_valid && take_ready));

  assert_save_clears_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    save_stb |-> (!ie_flag && $rose(busy)));

  assert_offer_follows_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
    save_stb |=> take_valid);

  assert_offer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready) |=> (take_valid && $stable(take_idx) && $stable(take_addr)));

  assert_restore_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_stb |=> !busy);

  assert_restore_after_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_stb) |-> $past(eoi));
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_done(exec_done), .eoi(eoi),
  .take_ready(take_ready), .ie_flag(ie_flag), .busy(busy),
  .save_stb(save_stb), .take_valid(take_valid), .take_idx(take_idx),
  .take_addr(take_addr), .nmi_ack(nmi_ack), .irq_ack(irq_ack),
  .restore_stb(restore_stb)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int N = 4;
  localparam int AW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic nmi_req = 1'b0, exec_done = 1'b0, ie_wr = 1'b0, ie_wdata = 1'b0;
  logic eoi = 1'b0, take_ready = 1'b0;
  logic ie_flag, busy, save_stb, take_valid, nmi_ack, restore_stb;
  logic [IW-1:0] take_idx;
  logic [AW-1:0] take_addr;
  logic [N-1:0] irq_ack;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  irq_ctrl #(.N_LINES(N), .ADDR_W(AW), .VEC_BASE(16'h0100), .VEC_STRIDE(16'h0010)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .exec_done(exec_done), .ie_wr(ie_wr), .ie_wdata(ie_wdata), .eoi(eoi),
    .take_ready(take_ready), .ie_flag(ie_flag), .busy(busy), .save_stb(save_stb),
    .take_valid(take_valid), .take_idx(take_idx), .take_addr(take_addr),
    .nmi_ack(nmi_ack), .irq_ack(irq_ack), .restore_stb(restore_stb)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_req = '0; nmi_req = 1'b0; exec_done = 1'b0;
    ie_wr = 1'b0; eoi = 1'b0; take_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [AW-1:0] vaddr(input int idx);
    return 16'h0100 + AW'(idx) * 16'h0010;
  endfunction

  // vector fields: {mask[3:0], nmi, ie, taken, idx[2:0]}
  // index 0 = non-maskable, k+1 = line k; priority nmi > line0 > line1 ...
  localparam logic [9:0] VECS [7] = '{
    {4'b1010, 1'b0, 1'b1, 1'b1, 3'd2},   // R4 line1 beats line3
    {4'b1000, 1'b0, 1'b1, 1'b1, 3'd4},   // R4 highest index alone
    {4'b1111, 1'b1, 1'b1, 1'b1, 3'd0},   // R4 nmi over all
    {4'b0011, 1'b0, 1'b0, 1'b0, 3'd0},   // R2 masked
    {4'b0101, 1'b1, 1'b0, 1'b1, 3'd0},   // R3 nmi with ie=0
    {4'b0001, 1'b0, 1'b1, 1'b1, 3'd1},   // R4 line0
    {4'b0100, 1'b0, 1'b1, 1'b1, 3'd3}    // R4 line2
  };

  initial begin
    // R9 reset state
    do_reset();
    @(negedge clk);
    chk(!busy && !save_stb && !take_valid && !restore_stb && !ie_flag && !nmi_ack && irq_ack == 0,
        "R9 reset outputs", {busy, save_stb, take_valid, restore_stb, ie_flag}, 0);

    for (int v = 0; v < 7; v++) begin
      logic [3:0] m; logic n, ie, tk; logic [2:0] ix;
      {m, n, ie, tk, ix} = VECS[v];
      do_reset();
      // one-cycle request pulses (R5 latching) plus enable write
      irq_req = m; nmi_req = n; ie_wr = 1'b1; ie_wdata = ie;
      @(negedge clk);
      irq_req = '0; nmi_req = 1'b0; ie_wr = 1'b0;
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
      if (!tk) begin
        chk(!busy && !save_stb, "R2 masked request ignored", busy, 0);
        @(negedge clk);
        chk(!take_valid && !busy, "R2 no offer while masked", take_valid, 0);
        continue;
      end
      chk(save_stb && busy, "R6 save strobe after accept", save_stb, 1);
      chk(!ie_flag, "R6 enable cleared on accept", ie_flag, 0);
      @(negedge clk);
      chk(take_valid && !save_stb, "R7 offer follows save", take_valid, 1);
      chk(take_idx == ix, "R4 winner index", take_idx, ix);
      chk(take_addr == vaddr(ix), "R7 vector address", take_addr, vaddr(ix));
      @(negedge clk);
      chk(take_valid && take_idx == ix && take_addr == vaddr(ix), "R7 offer held without ready",
          take_idx, ix);
      chk(!nmi_ack && irq_ack == 0, "R5 no ack before ready", irq_ack, 0);
      take_ready = 1'b1;
      #1;
      chk({irq_ack, nmi_ack} == (5'b1 << ix), "R5 one-hot ack on handshake", {irq_ack, nmi_ack}, 5'b1 << ix);
      @(negedge clk);
      take_ready = 1'b0;
      chk(!take_valid && busy, "R8 in service after handshake", {take_valid, busy}, 1);
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
      chk(restore_stb, "R8 restore strobe after eoi", restore_stb, 1);
      @(negedge clk);
      chk(!busy && ie_flag == ie, "R8 enable restored, idle", {busy, ie_flag}, {1'b0, ie});
    end

    // R1: no acceptance without the boundary pulse
    do_reset();
    ie_wr = 1'b1; ie_wdata = 1'b1; irq_req = 4'b0010;
    @(negedge clk);
    ie_wr = 1'b0; irq_req = '0;
    repeat (5) @(negedge clk);
    chk(!busy && !take_valid, "R1 pending held until exec_done", busy, 0);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    chk(busy && save_stb, "R1 accepted at boundary", busy, 1);
    @(negedge clk);
    chk(take_idx == 3'd2, "R5 latched pulse still pending", take_idx, 2);
    take_ready = 1'b1;
    @(negedge clk);
    take_ready = 1'b0;
    // R8 no nesting: new nmi and boundary during service
    nmi_req = 1'b1; exec_done = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0; exec_done = 1'b0;
    @(negedge clk);
    chk(busy && !save_stb && !take_valid, "R8 no nesting in service", {save_stb, take_valid}, 0);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    @(negedge clk);
    chk(!busy && ie_flag, "R8 back to idle, enable 1", {busy, ie_flag}, 1);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    @(negedge clk);
    chk(take_valid && take_idx == 3'd0, "R5 nmi held through service", take_idx, 0);
    take_ready = 1'b1;
    @(negedge clk);
    take_ready = 1'b0; eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    @(negedge clk);
    // R5 acknowledged source cleared: nothing left pending
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    chk(!busy && !save_stb, "R5 acked sources cleared", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule